// File: doc/BRIEF.md
# Multi-format serial audio deserializer

This block takes a two-channel serial audio stream and turns it into parallel sample pairs. Three pins carry the stream: a bit clock, a frame clock that selects the channel, and a data line. In slave operation all three are inputs from an external transmitter. They are resynchronised into a fast system clock, and a data bit is taken at each rising bit-clock edge. A 3-bit format code picks one of three framings. In the first two, the sample is aligned to the frame-clock transition, with the MSB either on the first bit clock after the transition or one bit clock later. In the right-justified framings, the sample is aligned to the end of the half-frame and its word length is chosen by the code.

Each completed word is left-aligned into a 24-bit sample. A half-frame may carry any number of bit clocks, and bits the format does not use are discarded. The left word is held until the right word that follows it completes. The pair is then offered on a valid/ready output.

Back-pressure rules are as follows. The serial stream cannot be stalled, so `out_valid` stays high with stable data until `out_ready` is seen high on a clock edge. If a newer pair completes while one is still pending, the newer pair replaces it, and the older pair is lost. With `out_ready` held high, each pair appears as a one-cycle pulse on `out_valid`.

Top module: `audio_deser`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 and both sample outputs are 0 until the first pair completes.
- R2: Format code 3'b000 (left-justified): a high frame clock marks the left channel. The MSB is the bit taken at the first rising bit clock after a frame-clock change. Up to 24 bits are kept, and further bits in the half-frame are ignored.
- R3: Format code 3'b001 (I²S): a low frame clock marks the left channel. The MSB is the bit taken one bit clock after the first rising bit clock that follows a frame-clock change. Up to 24 bits are kept.
- R4: Format codes 3'b010, 3'b011, 3'b100 and 3'b101 (right-justified, high frame clock = left) keep only the last 24, 20, 18 and 16 bits before the next frame-clock change. All earlier bits of the half-frame are ignored.
- R5: Samples are MSB-first and left-aligned in 24 bits, with every unused low bit zero. This includes a left-justified or I²S half-frame shorter than 24 bit clocks.
- R6: Format codes 3'b110 and 3'b111 never produce an output pair.
- R7: A pair is offered only after a left word and then a right word have both completed. A word completes when the next half-frame is detected. The partial word in progress at reset release or at a format change is discarded.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the samples stay stable until a newer pair completes. A newer pair replaces the pending one.
- R9: In the cycle after `out_valid` and `out_ready` are both high, `out_valid` is low unless a new pair completed in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 3 | Framing and word-length code |
| ser_bclk | input | 1 | Serial bit clock (asynchronous) |
| ser_fclk | input | 1 | Serial frame / channel clock (asynchronous) |
| ser_data | input | 1 | Serial data line (asynchronous) |
| out_valid | output | 1 | Sample pair available |
| out_ready | input | 1 | Consumer accepts the pair |
| out_left | output | 24 | Left sample, left-aligned |
| out_right | output | 24 | Right sample, left-aligned |

## Verification
Different internal faults show up in different ways at the ports:
- A wrong bit counter or positional write shows as samples shifted by one or more bits, or as non-zero low bits, in the first pair after a full left and right half-frame.
- A wrong channel polarity or a missed boundary swaps or merges the left and right samples, and this is visible in the very first pair offered.
- A faulty pending-pair register shows within a cycle or two of a withheld or granted `out_ready`: either `out_valid` drops early or it stays high after acceptance.
- A reserved code leaking through appears as any pair at all.

// File: rtl/audio_deser_pkg.sv
package audio_deser_pkg;

  localparam int SAMPLE_W = 24;

  typedef enum logic [1:0] {
    FR_LJ   = 2'd0,
    FR_I2S  = 2'd1,
    FR_RJ   = 2'd2,
    FR_NONE = 2'd3
  } frame_style_e;

  function automatic frame_style_e style_of(input logic [2:0] code);
    case (code)
      3'b000:                         return FR_LJ;
      3'b001:                         return FR_I2S;
      3'b010, 3'b011, 3'b100, 3'b101: return FR_RJ;
      default:                        return FR_NONE;
    endcase
  endfunction

  function automatic int rj_len(input logic [2:0] code);
    case (code)
      3'b011:  return 20;
      3'b100:  return 18;
      3'b101:  return 16;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/audio_pin_sync.sv
module audio_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic fclk_in,
  input  logic data_in,
  output logic bit_strobe,
  output logic fclk_s,
  output logic data_s
);
  // bit 0 = bit clock, bit 1 = frame clock, bit 2 = data
  logic [2:0] pipe [STAGES];
  logic       bclk_last;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= {data_in, fclk_in, bclk_in};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bclk_last <= 1'b0;
    else        bclk_last <= pipe[STAGES-1][0];
  end

  assign bit_strobe = pipe[STAGES-1][0] & ~bclk_last;
  assign fclk_s     = pipe[STAGES-1][1];
  assign data_s     = pipe[STAGES-1][2];

endmodule

// File: rtl/audio_word_capture.sv
module audio_word_capture
  import audio_deser_pkg::*;
#(
  parameter int W = SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   fmt,
  input  logic         bit_strobe,
  input  logic         fclk,
  input  logic         sdata,
  output logic         word_done,
  output logic         word_left,
  output logic [W-1:0] word
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(W);

  frame_style_e     style;
  logic [2:0]       fmt_q;
  logic             f1, f2;
  logic [1:0]       hist;
  logic             aligned;
  logic             cur_left;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     pos_reg, pos_next, tail_reg, assembled;
  logic             boundary, left_now;
  int               rj_n;

  assign style    = style_of(fmt_q);
  assign rj_n     = rj_len(fmt_q);
  assign boundary = (hist == 2'd2) &&
                    ((style == FR_I2S) ? (f1 != f2) : (fclk != f1));
  assign left_now = (style == FR_I2S) ? ~f1 : fclk;

  always_comb begin
    pos_next = pos_reg;
    for (int i = 0; i < W; i++)
      if (cnt < CNT_MAX && int'(cnt) == W - 1 - i) pos_next[i] = sdata;
  end

  assign assembled = (style == FR_RJ) ? (tail_reg << (W - rj_n)) : pos_reg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_done <= 1'b0;
      word_left <= 1'b0;
      word      <= '0;
      fmt_q     <= fmt;
      f1        <= 1'b0;
      f2        <= 1'b0;
      hist      <= '0;
      aligned   <= 1'b0;
      cur_left  <= 1'b0;
      cnt       <= '0;
      pos_reg   <= '0;
      tail_reg  <= '0;
    end else begin
      word_done <= 1'b0;
      fmt_q     <= fmt;
      if (fmt != fmt_q) begin
        aligned <= 1'b0;
        hist    <= '0;
      end else if (bit_strobe) begin
        f1 <= fclk;
        f2 <= f1;
        if (hist != 2'd2) hist <= hist + 2'd1;
        if (boundary) begin
          if (aligned) begin
            word_done <= 1'b1;
            word      <= assembled;
            word_left <= cur_left;
          end
          aligned  <= (style != FR_NONE);
          cur_left <= left_now;
          pos_reg  <= {sdata, {(W-1){1'b0}}};
          tail_reg <= {{(W-1){1'b0}}, sdata};
          cnt      <= CNT_W'(1);
        end else begin
          pos_reg  <= pos_next;
          tail_reg <= {tail_reg[W-2:0], sdata};
          if (cnt < CNT_MAX) cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // R6
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (style != FR_NONE));

  // R5
  rj16_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && fmt_q == 3'b101) |-> (word[W-17:0] == '0));

endmodule

// File: rtl/audio_pair_out.sv
module audio_pair_out #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_done,
  input  logic         word_left,
  input  logic [W-1:0] word,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right
);
  logic [W-1:0] left_hold;
  logic         have_left;
  logic         new_pair;

  assign new_pair = word_done && !word_left && have_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_hold <= '0;
      have_left <= 1'b0;
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      if (word_done && word_left) begin
        left_hold <= word;
        have_left <= 1'b1;
      end
      if (new_pair) begin
        out_left  <= left_hold;
        out_right <= word;
        out_valid <= 1'b1;
        have_left <= 1'b0;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R8
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !new_pair) |=> ($stable(out_left) && $stable(out_right)));

  // R7
  pair_after_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(word_done && !word_left));

endmodule

// File: rtl/audio_deser.sv
module audio_deser
  import audio_deser_pkg::*;
#(
  parameter int W           = SAMPLE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   fmt_sel,
  input  logic         ser_bclk,
  input  logic         ser_fclk,
  input  logic         ser_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right
);
  logic         bit_strobe, fclk_s, data_s;
  logic         word_done, word_left;
  logic [W-1:0] word;

  audio_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_in    (ser_bclk),
    .fclk_in    (ser_fclk),
    .data_in    (ser_data),
    .bit_strobe (bit_strobe),
    .fclk_s     (fclk_s),
    .data_s     (data_s)
  );

  audio_word_capture #(.W(W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt        (fmt_sel),
    .bit_strobe (bit_strobe),
    .fclk       (fclk_s),
    .sdata      (data_s),
    .word_done  (word_done),
    .word_left  (word_left),
    .word       (word)
  );

  audio_pair_out #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_done (word_done),
    .word_left (word_left),
    .word      (word),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right)
  );

  // R9
  release_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !word_done) |=> !out_valid);

endmodule

// File: tb/tb_audio_deser.sv
module tb_audio_deser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt_sel = 3'b000;
  logic        ser_bclk = 1'b0, ser_fclk = 1'b0, ser_data = 1'b0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [23:0] out_left, out_right;

  int n_cmp = 0, n_bad = 0, pair_n = 0;
  logic [23:0] got_l [4];
  logic [23:0] got_r [4];
  logic        prev_bit = 1'b1;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  audio_deser dut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
    .ser_bclk(ser_bclk), .ser_fclk(ser_fclk), .ser_data(ser_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_left(out_left), .out_right(out_right)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (pair_n < 4) begin
        got_l[pair_n] = out_left;
        got_r[pair_n] = out_right;
      end
      pair_n = pair_n + 1;
    end
  end

  // fields: fmt[106:104] bph[103:96] L0 R0 L1 R1
  localparam int NV = 11;
  localparam logic [106:0] VEC [NV] = '{
    {3'b000, 8'd32, 24'hA5C3F1, 24'h1E2D3C, 24'h800001, 24'h7FFFFE}, // R2
    {3'b000, 8'd16, 24'hA5C3F1, 24'h1E2D3C, 24'h123456, 24'hFEDCBA}, // R5
    {3'b001, 8'd32, 24'hC0FFEE, 24'h135799, 24'h800000, 24'h000001}, // R3
    {3'b001, 8'd24, 24'h5A5A5A, 24'hA5A5A5, 24'hFFFFFF, 24'h000000}, // R3
    {3'b001, 8'd16, 24'hBEEF77, 24'h4321AA, 24'h0F0F0F, 24'hF0F0F0}, // R5
    {3'b010, 8'd32, 24'h9ABCDE, 24'h024680, 24'h111111, 24'hEEEEEE}, // R4
    {3'b011, 8'd32, 24'h9ABCDE, 24'h024680, 24'h13579B, 24'hFDB975}, // R4
    {3'b100, 8'd24, 24'hFFFFC0, 24'h3C3C00, 24'h8001C0, 24'h7FFE40}, // R4
    {3'b101, 8'd32, 24'hDEAD00, 24'hBEEF00, 24'h0001FF, 24'hFF0100}, // R4
    {3'b110, 8'd32, 24'h111111, 24'h222222, 24'h333333, 24'h444444}, // R6
    {3'b111, 8'd24, 24'h555555, 24'h666666, 24'h777777, 24'h888888}  // R6
  };

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wlen(input logic [2:0] f);
    case (f)
      3'b011:  return 20;
      3'b100:  return 18;
      3'b101:  return 16;
      default: return 24;
    endcase
  endfunction

  function automatic logic slot_bit(input logic [2:0] f, input int bph,
                                    input logic [23:0] w, input int i);
    int n;
    if (f == 3'b000 || f == 3'b001) return (i < 24) ? w[23-i] : 1'b1;
    n = wlen(f);
    if (i < bph - n) return 1'b1;
    return w[23 - (i - (bph - n))];
  endfunction

  function automatic logic [23:0] expect_word(input logic [2:0] f, input int bph,
                                              input logic [23:0] w);
    if (f == 3'b000 || f == 3'b001)
      return (bph >= 24) ? w : (w & (24'hFFFFFF << (24 - bph)));
    return w & (24'hFFFFFF << (24 - wlen(f)));
  endfunction

  task automatic send_half(input logic lvl, input logic [2:0] f, input int bph,
                           input logic [23:0] w);
    for (int i = 0; i < bph; i++) begin
      logic cb;
      cb = slot_bit(f, bph, w, i);
      @(negedge clk);
      ser_fclk = lvl;
      ser_data = (f == 3'b001) ? prev_bit : cb;
      prev_bit = cb;
      repeat (4) @(negedge clk);
      ser_bclk = 1'b1;
      repeat (4) @(negedge clk);
      ser_bclk = 1'b0;
    end
  endtask

  task automatic run_stream(input logic [2:0] f, input int bph,
                            input logic [23:0] l0, input logic [23:0] r0,
                            input logic [23:0] l1, input logic [23:0] r1);
    logic lft;
    lft = (f == 3'b001) ? 1'b0 : 1'b1;
    send_half(~lft, f, bph, 24'hFFFFFF);
    send_half(lft, f, bph, l0);
    send_half(~lft, f, bph, r0);
    send_half(lft, f, bph, l1);
    send_half(~lft, f, bph, r1);
    send_half(lft, f, bph, 24'h000000);
    repeat (10) @(negedge clk);
  endtask

  task automatic do_reset(input logic [2:0] f);
    @(negedge clk);
    rst_n = 1'b0;
    fmt_sel = f;
    ser_bclk = 1'b0;
    ser_fclk = 1'b0;
    ser_data = 1'b0;
    prev_bit = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    pair_n = 0;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset(3'b000);
    check("R1 reset state", {23'd0, out_valid, out_left[23:0]}, 48'd0);
    check("R1 reset right", {24'd0, out_right}, 48'd0);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] f;
      int bph;
      f   = VEC[v][106:104];
      bph = int'(VEC[v][103:96]);
      do_reset(f);
      run_stream(f, bph, VEC[v][95:72], VEC[v][71:48], VEC[v][47:24], VEC[v][23:0]);
      if (f == 3'b110 || f == 3'b111) begin
        check("R6 reserved code gives no pair", 48'(pair_n), 48'd0);
      end else begin
        check("R7 two pairs, partial lead-in dropped", 48'(pair_n), 48'd2);
        check("R2 R3 R4 R5 pair 0", {got_l[0], got_r[0]},
              {expect_word(f, bph, VEC[v][95:72]), expect_word(f, bph, VEC[v][71:48])});
        check("R2 R3 R4 R5 pair 1", {got_l[1], got_r[1]},
              {expect_word(f, bph, VEC[v][47:24]), expect_word(f, bph, VEC[v][23:0])});
      end
    end

    // R8: back-pressure holds and newer pair replaces older
    do_reset(3'b000);
    out_ready = 1'b0;
    run_stream(3'b000, 32, 24'h010203, 24'h040506, 24'hA0B0C0, 24'hD0E0F0);
    check("R8 valid held while not ready", {47'd0, out_valid}, 48'd1);
    check("R8 newer pair replaces pending", {out_left, out_right}, {24'hA0B0C0, 24'hD0E0F0});
    repeat (20) @(negedge clk);
    check("R8 still held later", {out_valid, out_left, out_right[22:0]},
          {1'b1, 24'hA0B0C0, 23'h50E0F0});
    // R9: release after acceptance
    out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 valid drops after accept", {47'd0, out_valid}, 48'd0);
    check("R9 exactly one acceptance", 48'(pair_n), 48'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule